// File: doc/BRIEF.md
# Double-Precision to Integer Converter with Wrap Mode

This unit takes a 64-bit IEEE-754 double and produces a 32-bit or 64-bit integer, signed or unsigned. Rounding is always toward zero: the fraction is dropped before any range check or wrap. The result is held in a 64-bit output register.

A mode input picks one of two behaviours. Saturating mode clamps any value outside the range to the nearest limit and raises an invalid-conversion flag. Wrap mode follows the script-language convention: the truncated integer is reduced modulo 2^N, and a 32-bit result is zero-extended into the 64-bit word. In wrap mode only NaN and the infinities are invalid.

A signalling-NaN flag and an invalid-conversion flag come out with each result. When the invalid-exception enable is set and either flag is raised, the conversion traps. A trapped conversion does not update the result register and does not pulse the write strobe. The overflow output is always low.

Top module: `f2i_conv`

## Requirements
- R1: While reset is low and in the first cycle after it, the result is zero and done, res_we, snan_flag, cvi_flag, trap and ovf_flag are all low.
- R2: done is high in exactly the cycle after an accepted input (in_valid high) and low otherwise. The flags and trap are low whenever done is low.
- R3: The fmt encodings are 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit and 3 = unsigned 64-bit. In saturating mode (wrap_mode low), a finite in-range value becomes its truncated integer with cvi_flag low. A signed 32-bit result is sign-extended to 64 bits and an unsigned 32-bit result is zero-extended.
- R4: In saturating mode, +inf and finite values above the format maximum give the maximum. -inf and values below the minimum give the minimum. Each of these raises cvi_flag.
- R5: In saturating mode, a NaN gives the format minimum for signed formats (0xFFFFFFFF80000000 for fmt 0, 0x8000000000000000 for fmt 2) and zero for unsigned formats, and raises cvi_flag.
- R6: In saturating unsigned mode, a negative input whose truncation is zero (such as -0.5 or -0.0) gives 0 with cvi_flag low. A negative input of magnitude 1 or more gives 0 with cvi_flag high.
- R7: In wrap mode, a finite input of any magnitude gives the truncated integer modulo 2^N, with cvi_flag low. N is 32 for fmt 0 and 1 and 64 for fmt 2 and 3. For the 32-bit formats bits 63:32 of the result are zero.
- R8: In wrap mode, NaN and both infinities give 0 and raise cvi_flag.
- R9: snan_flag is high when the exponent field (bits 62:52) is all ones, the fraction (bits 51:0) is nonzero and fraction bit 51 is zero. Any such input also raises cvi_flag.
- R10: trap equals inv_en AND (snan_flag OR cvi_flag) for the conversion just done. When trap is high, res_we is low and the result keeps its previous value. Otherwise res_we is high and the result is updated.
- R11: ovf_flag is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand and controls valid this cycle |
| operand | input | 64 | IEEE-754 double to convert |
| fmt | input | 2 | Target format: 0 s32, 1 u32, 2 s64, 3 u64 |
| wrap_mode | input | 1 | 1 = modular wrap, 0 = saturate |
| inv_en | input | 1 | Invalid-exception enable |
| result | output | 64 | Converted integer (held on trap) |
| res_we | output | 1 | Result was written this cycle |
| done | output | 1 | Conversion finished this cycle |
| snan_flag | output | 1 | Input was a signalling NaN |
| cvi_flag | output | 1 | Invalid conversion |
| trap | output | 1 | Enabled invalid exception; write suppressed |
| ovf_flag | output | 1 | Overflow indication, always 0 |

## Verification
Every output of a conversion is due one clock edge after the cycle in which in_valid is high: result, res_we, done, both flags and trap all come from one register stage. The bench changes its inputs on the falling edge and samples on the next falling edge, half a period after the capturing rising edge. It also samples one cycle later to see done and the strobes drop. Expected values come from a wide-integer model of truncation, which is exact up to 2^180. Above that the low 64 bits are known to be zero.

// File: rtl/f2i_pkg.sv
// Shared widths, the target-format encoding and the classified-operand
// record used by the float-to-integer converter.
package f2i_pkg;
    localparam int FP_W     = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        FMT_S32 = 2'd0,
        FMT_U32 = 2'd1,
        FMT_S64 = 2'd2,
        FMT_U64 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_inf;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } fp_class_t;
endpackage

// File: rtl/f2i_unpack.sv
// Splits a double into its fields and classifies it (NaN, signalling NaN,
// infinity). Assumes IEEE-754 binary64 layout; subnormals keep a zero
// hidden bit.
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    output fp_class_t       cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    // Field extraction and special-value classification.
    always_comb begin
        exp_f       = operand[FP_W-2 -: EXP_W];
        frac_f      = operand[FRAC_W-1:0];
        exp_max     = &exp_f;
        cls.sign    = operand[FP_W-1];
        cls.is_nan  = exp_max && (frac_f != '0);
        cls.is_snan = exp_max && (frac_f != '0) && !frac_f[FRAC_W-1];
        cls.is_inf  = exp_max && (frac_f == '0);
        cls.exp     = exp_f;
        cls.sig     = {|exp_f, frac_f};
    end
endmodule

// File: rtl/f2i_trunc.sv
// Truncates the magnitude of a finite double toward zero. Produces the
// integer magnitude modulo 2^INT_W and a flag for magnitude >= 2^INT_W.
// Assumes the caller handles NaN and infinity separately.
module f2i_trunc
    import f2i_pkg::*;
(
    input  fp_class_t        cls,
    output logic [INT_W-1:0] mag,
    output logic             mag_big
);
    localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] FRAC_E = EXP_W'(FRAC_W);
    localparam logic [EXP_W-1:0] WIDE_E = EXP_W'(FRAC_W + INT_W);
    localparam logic [EXP_W-1:0] INT_E  = EXP_W'(INT_W);

    logic [EXP_W-1:0] sh;
    logic [INT_W-1:0] sig_x;

    // Shift the significand so the binary point sits below bit 0.
    always_comb begin
        sh      = cls.exp - BIAS_E;
        sig_x   = INT_W'(cls.sig);
        mag     = '0;
        mag_big = 1'b0;
        if (cls.exp >= BIAS_E) begin
            mag_big = (sh >= INT_E);
            if (sh <= FRAC_E) begin
                mag = sig_x >> (FRAC_E - sh);
            end else if (sh < WIDE_E) begin
                mag = sig_x << (sh - FRAC_E);
            end
        end
    end
endmodule

// File: rtl/f2i_select.sv
// Picks the final 64-bit integer from the truncated magnitude. It either
// clamps to the target range or wraps modulo 2^N, and raises the
// invalid-conversion flag. Assumes mag/mag_big come from f2i_trunc.
module f2i_select
    import f2i_pkg::*;
(
    input  fp_class_t        cls,
    input  logic [INT_W-1:0] mag,
    input  logic             mag_big,
    input  fmt_e             fmt,
    input  logic             wrap_mode,
    output logic [INT_W-1:0] res,
    output logic             cvi
);
    localparam logic [INT_W-1:0] ONE      = INT_W'(1);
    localparam logic [INT_W-1:0] N_UMAX   = (ONE << NARROW_W) - ONE;
    localparam logic [INT_W-1:0] N_SMAX   = (ONE << (NARROW_W - 1)) - ONE;
    localparam logic [INT_W-1:0] N_SNEG   = ONE << (NARROW_W - 1);
    localparam logic [INT_W-1:0] W_SMAX   = (ONE << (INT_W - 1)) - ONE;
    localparam logic [INT_W-1:0] W_SNEG   = ONE << (INT_W - 1);

    logic             narrow;
    logic             uns;
    logic [INT_W-1:0] pos_lim;
    logic [INT_W-1:0] neg_lim;
    logic [INT_W-1:0] min_val;
    logic [INT_W-1:0] signed_val;

    // Range limits for the selected format.
    always_comb begin
        narrow  = (fmt == FMT_S32) || (fmt == FMT_U32);
        uns     = (fmt == FMT_U32) || (fmt == FMT_U64);
        if (narrow) pos_lim = uns ? N_UMAX : N_SMAX;
        else        pos_lim = uns ? '1 : W_SMAX;
        if (uns)    neg_lim = '0;
        else        neg_lim = narrow ? N_SNEG : W_SNEG;
        min_val    = ~neg_lim + ONE;
        signed_val = cls.sign ? (~mag + ONE) : mag;
    end

    // Saturating or modular result selection.
    always_comb begin
        res = '0;
        cvi = 1'b0;
        if (wrap_mode) begin
            if (cls.is_nan || cls.is_inf) begin
                cvi = 1'b1;
            end else if (narrow) begin
                res = {{(INT_W-NARROW_W){1'b0}}, signed_val[NARROW_W-1:0]};
            end else begin
                res = signed_val;
            end
        end else if (cls.is_nan) begin
            res = min_val;
            cvi = 1'b1;
        end else if (cls.is_inf) begin
            res = cls.sign ? min_val : pos_lim;
            cvi = 1'b1;
        end else if (cls.sign) begin
            if (mag_big || (mag > neg_lim)) begin
                res = min_val;
                cvi = 1'b1;
            end else begin
                res = signed_val;
            end
        end else begin
            if (mag_big || (mag > pos_lim)) begin
                res = pos_lim;
                cvi = 1'b1;
            end else begin
                res = mag;
            end
        end
    end
endmodule

// File: rtl/f2i_conv.sv
// Top of the float-to-integer converter. It registers the result and the
// flags one cycle after in_valid. The result register is updated only
// when no enabled invalid exception occurs. Assumes synchronous
// active-low reset.
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  operand,
    input  logic [1:0]       fmt,
    input  logic             wrap_mode,
    input  logic             inv_en,
    output logic [INT_W-1:0] result,
    output logic             res_we,
    output logic             done,
    output logic             snan_flag,
    output logic             cvi_flag,
    output logic             trap,
    output logic             ovf_flag
);
    fp_class_t        cls;
    logic [INT_W-1:0] mag;
    logic             mag_big;
    logic [INT_W-1:0] res_d;
    logic             cvi_d;
    logic             trap_d;

    f2i_unpack u_unpack (
        .operand (operand),
        .cls     (cls)
    );

    f2i_trunc u_trunc (
        .cls     (cls),
        .mag     (mag),
        .mag_big (mag_big)
    );

    f2i_select u_select (
        .cls       (cls),
        .mag       (mag),
        .mag_big   (mag_big),
        .fmt       (fmt_e'(fmt)),
        .wrap_mode (wrap_mode),
        .res       (res_d),
        .cvi       (cvi_d)
    );

    // Exception trigger for the current operand.
    always_comb begin
        trap_d = inv_en && (cls.is_snan || cvi_d);
    end

    // Status register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            snan_flag <= 1'b0;
            cvi_flag  <= 1'b0;
            trap      <= 1'b0;
        end else begin
            done      <= in_valid;
            snan_flag <= in_valid && cls.is_snan;
            cvi_flag  <= in_valid && cvi_d;
            trap      <= in_valid && trap_d;
        end
    end

    // Result register, written only when no exception is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid && !trap_d) begin
            result <= res_d;
        end
    end

    // Write strobe and the always-clear overflow indication.
    always_comb begin
        res_we   = done && !trap;
        ovf_flag = 1'b0;
    end
endmodule

// File: rtl/f2i_conv_chk.sv
// Temporal checks on the converter ports, bound into every f2i_conv.
module f2i_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  fmt,
    input logic        wrap_mode,
    input logic        inv_en,
    input logic [63:0] result,
    input logic        res_we,
    input logic        done,
    input logic        snan_flag,
    input logic        cvi_flag,
    input logic        trap
);
    // R2
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R2
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!snan_flag && !cvi_flag && !trap));

    // R9
    snan_implies_cvi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snan_flag |-> cvi_flag);

    // R10
    trap_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap) |-> $stable(result));

    // R10
    no_trap_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_en) |=> !trap);

    // R7
    wrap_narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wrap_mode && !fmt[1]) |=> (!res_we || result[63:32] == 32'd0));

    // R3
    u32_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'd1) |=> (!res_we || result[63:32] == 32'd0));
endmodule

bind f2i_conv f2i_conv_chk u_chk (.*);

// File: tb/f2i_conv_tb.sv
module f2i_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  fmt = '0;
    logic        wrap_mode = 1'b0;
    logic        inv_en = 1'b0;
    logic [63:0] result;
    logic        res_we, done, snan_flag, cvi_flag, trap, ovf_flag;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] prev_res = '0;

    always #4 clk = ~clk;

    f2i_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .fmt(fmt), .wrap_mode(wrap_mode), .inv_en(inv_en), .result(result),
        .res_we(res_we), .done(done), .snan_flag(snan_flag),
        .cvi_flag(cvi_flag), .trap(trap), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference model: exact wide-integer truncation, then range rules.
    function automatic void ref_conv(input logic [63:0] op, input logic [1:0] f,
                                     input logic wr, output logic [63:0] r,
                                     output logic cvi, output logic snan,
                                     output string tag);
        logic [255:0] m, w, posmax, negmax, v, mn;
        logic [10:0]  e;
        logic [51:0]  fr;
        logic         s, nan, inf, uns;
        int           n, sh;
        e   = op[62:52];
        fr  = op[51:0];
        s   = op[63];
        nan = (e == 11'h7FF) && (fr != 0);
        inf = (e == 11'h7FF) && (fr == 0);
        snan = nan && !fr[51];
        n   = f[1] ? 64 : 32;
        uns = f[0];
        posmax = uns ? ((256'(1) << n) - 1) : ((256'(1) << (n - 1)) - 1);
        negmax = uns ? 256'(0) : (256'(1) << (n - 1));
        mn = 256'(0) - negmax;
        m = '0;
        if (!nan && !inf && e >= 11'd1023) begin
            sh = int'(e) - 1023;
            if (sh > 180) m = 256'(1) << 200;
            else begin
                w = {203'b0, 1'b1, fr} << sh;
                m = w >> 52;
            end
        end
        v = s ? (256'(0) - m) : m;
        if (wr) begin
            tag = snan ? "R9" : ((nan || inf) ? "R8" : "R7");
            if (nan || inf) begin r = '0; cvi = 1'b1; end
            else begin
                cvi = 1'b0;
                r = (n == 32) ? {32'b0, v[31:0]} : v[63:0];
            end
        end else if (nan) begin
            tag = snan ? "R9" : "R5"; cvi = 1'b1; r = mn[63:0];
        end else if (inf) begin
            tag = "R4"; cvi = 1'b1; r = s ? mn[63:0] : posmax[63:0];
        end else if (s && m > negmax) begin
            tag = uns ? "R6" : "R4"; cvi = 1'b1; r = mn[63:0];
        end else if (!s && m > posmax) begin
            tag = "R4"; cvi = 1'b1; r = posmax[63:0];
        end else begin
            tag = (uns && s) ? "R6" : "R3"; cvi = 1'b0; r = v[63:0];
        end
    endfunction

    task automatic run_op(input logic [63:0] op, input logic [1:0] f,
                          input logic wr, input logic ie);
        logic [63:0] r, res_e;
        logic        cvi, snan, trap_e;
        string       tag;
        @(negedge clk);
        operand = op; fmt = f; wrap_mode = wr; inv_en = ie; in_valid = 1'b1;
        ref_conv(op, f, wr, r, cvi, snan, tag);
        trap_e = ie && (snan || cvi);
        res_e  = trap_e ? prev_res : r;
        @(negedge clk);
        in_valid = 1'b0;
        chk(trap_e ? "R10" : tag, "result", result, res_e);
        chk("R2", "done", 64'(done), 64'd1);
        chk("R10", "res_we", 64'(res_we), 64'(!trap_e));
        chk("R10", "trap", 64'(trap), 64'(trap_e));
        chk("R9", "snan_flag", 64'(snan_flag), 64'(snan));
        chk(tag, "cvi_flag", 64'(cvi_flag), 64'(cvi));
        chk("R11", "ovf_flag", 64'(ovf_flag), 64'd0);
        prev_res = res_e;
    endtask

    logic [63:0] specials [16] = '{
        64'h0000000000000000, 64'h8000000000000000, 64'h7FF0000000000000,
        64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001,
        64'hFFF4000000000000, 64'hBFE0000000000000, 64'h0000000000000001,
        64'hC1E0000000000000, 64'h41E0000000000000, 64'hC3E0000000000000,
        64'h43F0000000000000, 64'h7E70000000000000, 64'h41F0000000500000,
        64'hBFF0000000000000
    };
    logic [51:0] fracs [4] = '{52'h0, 52'hFFFFFFFFFFFFF, 52'h8000000000001, 52'h5555555555555};

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "result in reset", result, 64'd0);
        chk("R1", "done in reset", 64'(done), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "result", result, 64'd0);
        chk("R1", "strobes", {58'd0, done, res_we, snan_flag, cvi_flag, trap, ovf_flag}, 64'd0);

        // Special values over every format, mode and enable.
        for (int i = 0; i < 16; i++)
            for (int f = 0; f < 4; f++)
                for (int wr = 0; wr < 2; wr++)
                    for (int ie = 0; ie < 2; ie++)
                        run_op(specials[i], 2'(f), 1'(wr), 1'(ie));

        // Near-exhaustive exponent sweep around every range boundary.
        for (int e = 1020; e <= 1123; e++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 2; s++)
                    for (int f = 0; f < 4; f++)
                        for (int wr = 0; wr < 2; wr++)
                            run_op({1'(s), 11'(e), fracs[k]}, 2'(f), 1'(wr), 1'((e + k) % 3 == 0));

        // done and strobes fall in the idle cycle after a conversion.
        run_op(64'h4000000000000000, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2", "done idle", 64'(done), 64'd0);
        chk("R2", "res_we idle", 64'(res_we), 64'd0);
        chk("R2", "flags idle", {61'd0, snan_flag, cvi_flag, trap}, 64'd0);
        chk("R2", "result kept", result, 64'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule